// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a timer whose count advances once every programmable number of peripheral clocks. Seven match channels each hold a compare value. When the count first takes a channel's value, that channel can raise an interrupt flag, make the count wrap to zero at the next tick, or halt the timer. Each channel also drives its own match output. The output can be left alone, driven low, driven high or inverted on a match.

Software sets the block up through a single-cycle register write port. The writable items are the control bits, the prescale value, the interrupt-clear register, the per-channel action bits, the output actions and the seven compare values. Several channels can work together on one count. One channel can set the period through its wrap action while the others place edges on their outputs within that period.

Top module: `prescaled_match_timer`

Register addresses (`wrAddr`):

| Address | Contents |
|---|---|
| 0 | Control: bit 0 enables counting, bit 1 holds the count at zero |
| 1 | Prescale value |
| 2 | Interrupt clear: writing 1 to bit c clears the flag of channel c |
| 3 | Channel action bits: bit 3c interrupt, bit 3c+1 wrap, bit 3c+2 stop |
| 4 | Output action: bits 2c+1:2c of channel c |
| 8+c | Compare value of channel c |

## Requirements
- R1: While counting is enabled with prescale value P (register 1), `count` increments by one once every P+1 clocks. When P is zero it increments on every clock.
- R2: Counting is enabled by bit 0 of register 0. After reset, `count`, `irqFlags`, `matchOut` and `running` are all zero. While bit 0 is clear, `count` does not change.
- R3: While bit 1 of register 0 is set, the prescaler and `count` are held at zero, even if bit 0 is also set.
- R4: Channel c (compare value at address 8+c) has a match event once per timer tick, in the cycle in which `count` first takes its compare value. Staying at that value between ticks does not produce further events.
- R5: When channel c's wrap bit (register 3, bit 3c+1) is set, the tick after its match loads zero into `count` instead of incrementing it. The count period is then the compare value plus one ticks.
- R6: When channel c's stop bit (register 3, bit 3c+2) is set, its match clears the enable bit, which `running` shows. `count` then stays at the compare value.
- R7: When channel c's interrupt bit (register 3, bit 3c) is set, its match sets `irqFlags[c]` one clock after the match event.
- R8: Writing register 2 clears each `irqFlags` bit written as 1. Bits written as 0 keep their value.
- R9: On a match of channel c, `matchOut[c]` follows the two-bit code in register 4, bits 2c+1:2c: 00 leaves it unchanged, 01 drives it low, 10 drives it high, 11 inverts it.
- R10: When several channels match on the same tick, the actions of all of them apply together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Register write data |
| count | output | 16 | Current timer count |
| running | output | 1 | Enable bit of the control register |
| irqFlags | output | 7 | Per-channel interrupt flags |
| matchOut | output | 7 | Per-channel match outputs |

## Verification
A prescaler that slips its tick boundary changes how many clocks `count` holds each value, and this is visible at the first increment. A stale "new value" flag shows up within one tick. A flag cleared while the count still equals the compare value is raised again, and an inverting output flips twice. A wrong wrap or stop decision changes the count sequence at the next tick boundary. A missed output action is seen one clock after the match. The bench measures each of these cycle windows directly at the ports.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRE   = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_IRQCL = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_MCTL  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_EXT   = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_MV0   = 4'd8;

  typedef enum logic [1:0] {
    EXT_KEEP   = 2'b00,
    EXT_LOW    = 2'b01,
    EXT_HIGH   = 2'b10,
    EXT_INVERT = 2'b11
  } ext_act_t;

  // control -> datapath strobes
  typedef struct packed {
    logic run;    // advance prescaler this cycle
    logic clear;  // force prescaler and count to zero
    logic wrap;   // on a tick, load zero instead of incrementing
  } strobe_t;
endpackage

// File: rtl/ptm_datapath.sv
module ptm_datapath
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int NCH   = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [PRE_W-1:0]           prescale,
  input  logic [NCH-1:0][CNT_W-1:0]  matchVal,
  output logic [CNT_W-1:0]           count,
  output logic [NCH-1:0]             eqVec,
  output logic                       fresh
);
  logic [PRE_W-1:0] preCnt;
  logic             tickNow;

  // >= so that lowering the prescale value mid-count cannot strand preCnt
  assign tickNow = stb.run && (preCnt >= prescale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
      fresh  <= 1'b0;
    end else if (stb.clear) begin
      preCnt <= '0;
      count  <= '0;
      fresh  <= 1'b0;
    end else if (tickNow) begin
      preCnt <= '0;
      count  <= stb.wrap ? '0 : count + 1'b1;
      fresh  <= 1'b1;
    end else begin
      if (stb.run) preCnt <= preCnt + 1'b1;
      fresh <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign eqVec[c] = (count == matchVal[c]);
  end
endmodule

// File: rtl/ptm_control.sv
module ptm_control
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int NCH   = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NCH-1:0]             eqVec,
  input  logic                       fresh,
  output strobe_t                    stb,
  output logic [PRE_W-1:0]           prescale,
  output logic [NCH-1:0][CNT_W-1:0]  matchVal,
  output logic                       running,
  output logic [NCH-1:0]             irqFlags,
  output logic [NCH-1:0]             matchOut,
  output logic [NCH-1:0]             intMask,
  output logic [NCH-1:0]             stopMask,
  output logic [NCH-1:0]             invMask
);
  localparam int MCTL_W = 3 * NCH;
  localparam int EXT_W  = 2 * NCH;

  logic              enableReg, clearReg;
  logic [MCTL_W-1:0] mctlReg;
  logic [EXT_W-1:0]  extReg;
  logic [NCH-1:0]    hit, wrapMask;
  logic              stopHit;
  logic              wrCtrl, wrIrqClr;

  assign wrCtrl   = wrEn && (wrAddr == ADDR_CTRL);
  assign wrIrqClr = wrEn && (wrAddr == ADDR_IRQCL);
  assign hit      = eqVec & {NCH{fresh}};
  assign stopHit  = |(hit & stopMask);

  assign stb.run   = enableReg && !clearReg && !stopHit;
  assign stb.clear = clearReg;
  assign stb.wrap  = |(eqVec & wrapMask);
  assign running   = enableReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      clearReg  <= 1'b0;
      prescale  <= '0;
      mctlReg   <= '0;
      extReg    <= '0;
    end else begin
      if (stopHit)     enableReg <= 1'b0;
      else if (wrCtrl) enableReg <= wrData[0];
      if (wrCtrl) clearReg <= wrData[1];
      if (wrEn && wrAddr == ADDR_PRE)  prescale <= wrData[PRE_W-1:0];
      if (wrEn && wrAddr == ADDR_MCTL) mctlReg  <= wrData[MCTL_W-1:0];
      if (wrEn && wrAddr == ADDR_EXT)  extReg   <= wrData[EXT_W-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_MV0 + ADDR_W'(c);
    ext_act_t act;

    assign intMask[c]  = mctlReg[3*c];
    assign wrapMask[c] = mctlReg[3*c+1];
    assign stopMask[c] = mctlReg[3*c+2];
    assign act         = ext_act_t'(extReg[2*c +: 2]);
    assign invMask[c]  = (act == EXT_INVERT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchVal[c] <= '0;
        irqFlags[c] <= 1'b0;
        matchOut[c] <= 1'b0;
      end else begin
        if (wrEn && wrAddr == MY_ADDR) matchVal[c] <= wrData[CNT_W-1:0];
        // a new match event wins over a same-cycle clear
        if (hit[c] && intMask[c])          irqFlags[c] <= 1'b1;
        else if (wrIrqClr && wrData[c])    irqFlags[c] <= 1'b0;
        if (hit[c]) begin
          unique case (act)
            EXT_LOW:    matchOut[c] <= 1'b0;
            EXT_HIGH:   matchOut[c] <= 1'b1;
            EXT_INVERT: matchOut[c] <= ~matchOut[c];
            default:    matchOut[c] <= matchOut[c];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int NCH   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [31:0]       wrData,
  output logic [CNT_W-1:0]  count,
  output logic              running,
  output logic [NCH-1:0]    irqFlags,
  output logic [NCH-1:0]    matchOut
);
  strobe_t                   stb;
  logic [PRE_W-1:0]          prescale;
  logic [NCH-1:0][CNT_W-1:0] matchVal;
  logic [NCH-1:0]            eqVec, intMask, stopMask, invMask;
  logic                      fresh;

  ptm_control #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .eqVec(eqVec), .fresh(fresh), .stb(stb), .prescale(prescale),
    .matchVal(matchVal), .running(running), .irqFlags(irqFlags),
    .matchOut(matchOut), .intMask(intMask), .stopMask(stopMask),
    .invMask(invMask)
  );

  ptm_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .prescale(prescale),
    .matchVal(matchVal), .count(count), .eqVec(eqVec), .fresh(fresh)
  );
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
  parameter int CNT_W = 16,
  parameter int NCH   = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             clearing,
  input logic [NCH-1:0]   eqVec,
  input logic             fresh,
  input logic [NCH-1:0]   intMask,
  input logic [NCH-1:0]   stopMask,
  input logic [NCH-1:0]   invMask,
  input logic [NCH-1:0]   irqFlags,
  input logic [NCH-1:0]   matchOut
);
  logic [NCH-1:0] hit;
  assign hit = eqVec & {NCH{fresh}};

  // R1: count only holds, steps by one, or returns to zero
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0));

  // R2: disabled timer holds its count
  a_r2_disabled_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !clearing) |=> $stable(count));

  // R3: held clear forces zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearing |=> (count == '0));

  // R6: stop match drops the enable and freezes the count
  a_r6_stop_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (|(hit & stopMask)) |=> (!running && $stable(count)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R7: enabled match raises its flag
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
      (hit[c] && intMask[c]) |=> irqFlags[c]);
    // R9: invert action flips the output
    a_r9_invert: assert property (@(posedge clk) disable iff (!rstN)
      (hit[c] && invMask[c]) |=> (matchOut[c] != $past(matchOut[c])));
  end
endmodule

bind prescaled_match_timer ptm_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .count(count), .running(running),
  .clearing(stb.clear), .eqVec(eqVec), .fresh(fresh), .intMask(intMask),
  .stopMask(stopMask), .invMask(invMask), .irqFlags(irqFlags),
  .matchOut(matchOut)
);

// File: tb/tb_prescaled_match_timer.sv
module tb_prescaled_match_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [15:0] count;
  logic        running;
  logic [6:0]  irqFlags, matchOut;

  int testCount = 0;
  int failCount = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  prescaled_match_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .running(running), .irqFlags(irqFlags), .matchOut(matchOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 100000);
    failCount++; testCount++;
    $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCount(input int v);
    for (int i = 0; i < 2000 && count != 16'(v); i++) @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart();
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h0);
    wr(4'd2, 32'h7f);
  endtask

  task automatic t_reset();
    check(count == 0 && running == 0, "R2 reset count/running", int'(count), 0);
    check(irqFlags == 0 && matchOut == 0, "R2 reset flags/outputs",
          int'({irqFlags, matchOut}), 0);
  endtask

  task automatic t_prescale();
    int gap;
    wr(4'd3, 32'h0);
    wr(4'd1, 32'd2);
    wr(4'd0, 32'h1);
    waitCount(1);
    gap = 0;
    while (count == 1 && gap < 50) begin @(negedge clk); gap++; end
    check(gap == 3 && count == 2, "R1 prescale 2 gap", gap, 3);
    wr(4'd1, 32'd0);
    waitCycles(4);
    begin
      logic [15:0] prev;
      prev = count;
      @(negedge clk);
      check(count == prev + 1, "R1 prescale 0 step", int'(count), int'(prev) + 1);
    end
    wr(4'd0, 32'h0);
    begin
      logic [15:0] held;
      held = count;
      waitCycles(6);
      check(count == held, "R2 disabled holds", int'(count), int'(held));
    end
  endtask

  task automatic t_clear();
    wr(4'd0, 32'h3);
    waitCycles(4);
    check(count == 0, "R3 clear with enable", int'(count), 0);
    wr(4'd0, 32'h1);
    waitCycles(4);
    check(count != 0, "R3 released resumes", int'(count), 1);
    restart();
    check(count == 0, "R3 cleared after stop", int'(count), 0);
  endtask

  task automatic t_wrap();
    int peak = 0;
    restart();
    wr(4'd1, 32'd1);
    wr(4'd8, 32'd4);
    wr(4'd3, 32'h3);        // ch0 interrupt + wrap
    wr(4'd0, 32'h1);
    waitCount(4);
    while (count == 4) @(negedge clk);
    check(count == 0, "R5 wrap to zero", int'(count), 0);
    check(irqFlags[0] == 1, "R7 wrap channel flag", int'(irqFlags[0]), 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(count) > peak) peak = int'(count);
    end
    check(peak == 4, "R5 period peak", peak, 4);
  endtask

  task automatic t_once();
    restart();
    wr(4'd1, 32'd3);
    wr(4'd8, 32'd6);
    wr(4'd13, 32'd2);
    wr(4'd3, 32'h8002);     // ch0 wrap, ch5 interrupt
    wr(4'd0, 32'h1);
    waitCount(2);
    @(negedge clk);
    check(irqFlags[5] == 1, "R7 flag one clock after match", int'(irqFlags[5]), 1);
    wr(4'd2, 32'h0);
    check(irqFlags[5] == 1, "R8 zero write keeps flag", int'(irqFlags[5]), 1);
    wr(4'd2, 32'h20);
    check(irqFlags[5] == 0 && count == 2, "R8 one write clears flag",
          int'(irqFlags[5]), 0);
    waitCount(3);
    @(negedge clk);
    check(irqFlags[5] == 0, "R4 no repeat while value held", int'(irqFlags[5]), 0);
  endtask

  task automatic t_stop();
    restart();
    wr(4'd1, 32'd0);
    wr(4'd9, 32'd3);
    wr(4'd3, 32'h20);       // ch1 stop
    wr(4'd0, 32'h1);
    waitCycles(10);
    check(running == 0, "R6 enable cleared", int'(running), 0);
    check(count == 3, "R6 count at compare value", int'(count), 3);
    waitCycles(5);
    check(count == 3, "R6 stays stopped", int'(count), 3);
  endtask

  task automatic t_ext();
    restart();
    wr(4'd1, 32'd1);
    wr(4'd8, 32'd3);
    wr(4'd10, 32'd1);
    wr(4'd11, 32'd2);
    wr(4'd12, 32'd2);
    wr(4'd14, 32'd1);
    wr(4'd3, 32'h2);        // ch0 wrap
    wr(4'd4, 32'h2B0);      // ch2 invert, ch3 high, ch4 high, ch6 keep
    wr(4'd0, 32'h1);
    waitCount(3);
    waitCount(0);
    wr(4'd0, 32'h0);
    check(matchOut[2] == 1, "R9 invert first", int'(matchOut[2]), 1);
    check(matchOut[3] == 1 && matchOut[4] == 1, "R9 drive high",
          int'(matchOut[4:3]), 3);
    wr(4'd4, 32'h130);      // ch2 invert, ch3 keep, ch4 low
    wr(4'd0, 32'h1);
    waitCount(3);
    waitCount(0);
    wr(4'd0, 32'h0);
    check(matchOut[2] == 0, "R9 invert second", int'(matchOut[2]), 0);
    check(matchOut[3] == 1, "R9 keep", int'(matchOut[3]), 1);
    check(matchOut[4] == 0, "R9 drive low", int'(matchOut[4]), 0);
    check(matchOut[6] == 0, "R9 keep untouched", int'(matchOut[6]), 0);
  endtask

  task automatic t_multi();
    restart();
    wr(4'd1, 32'd0);
    wr(4'd9, 32'd5);
    wr(4'd10, 32'd5);
    wr(4'd14, 32'd5);
    wr(4'd3, 32'h68);       // ch1 interrupt + stop, ch2 interrupt
    wr(4'd4, 32'h3000);     // ch6 invert
    wr(4'd0, 32'h1);
    waitCycles(12);
    check(irqFlags[2:1] == 2'b11, "R10 both flags", int'(irqFlags[2:1]), 3);
    check(running == 0 && count == 5, "R10 stop applied", int'(count), 5);
    check(matchOut[6] == 1, "R10 output applied", int'(matchOut[6]), 1);
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_clear();
    t_wrap();
    t_once();
    t_stop();
    t_ext();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule